// File: doc/BRIEF.md
# Sector Erase Batching Timer

This block gathers sector-erase requests from a flash command decoder into a single batch. The first sector-erase request opens an accept window. Each further sector request, and each falling edge of the write strobe, restarts that window. When the window has been quiet for a programmed number of cycles, the block starts the erase on every sector collected so far.

The erase itself is modelled with counters. A zero-fill phase comes first and only writes the selected sectors. An erase phase follows, and its length grows with the number of sectors in the batch. A time limit watches the erase phase: running past it raises an overtime flag and parks the block until a new command arrives. Meanwhile a polling bit reads low for polls of any sector in the batch.

Any unrelated command that arrives during the window throws the whole batch away. Requests that arrive after the window has closed have no effect on the erase that is running.

Top module: `erase_batch_timer`

## Requirements
- R1: After reset, `phase_o` is 0 (read), `dq7_o` is 1, `dq5_o` is 0, `wr_mask_o` is all zero and no sector is selected.
- R2: In read phase, a `sec_cmd_i` pulse sets `phase_o` to 1 (window) on the next cycle and selects sector `sec_idx_i`. Each further `sec_cmd_i` in the window selects its sector too. Repeating a sector that is already selected changes nothing.
- R3: Either a `sec_cmd_i` or a `we_fall_i` pulse in the window restarts it. Phase 2 (zero-fill) starts exactly `WIN_CYC` cycles after the last such pulse, and a pulse that lands on the last window cycle still restarts the window.
- R4: An `other_cmd_i` pulse in the window returns `phase_o` to 0 on the next cycle, clears every selection and starts no erase. A `susp_cmd_i` pulse in the window neither aborts the batch nor restarts the window.
- R5: Zero-fill lasts `ZFILL_CYC` cycles and is then followed by phase 3 (erase). During phases 2 and 3, `wr_mask_o` bit i is 1 exactly when sector i is selected. In every other phase `wr_mask_o` is all zero.
- R6: The erase phase lasts `ERASE_CYC` times the number of selected sectors. When it completes, `phase_o` returns to 0, all selections clear and `dq7_o` reads 1.
- R7: A `sec_cmd_i` or `other_cmd_i` pulse during zero-fill or erase is ignored. The selection and the phase timing do not change. A `sec_cmd_i` pulse during overtime selects nothing.
- R8: `dq7_o` is 0 when `phase_o` is not 0 and sector `poll_sec_i` is selected. Otherwise it is 1. The output is registered, so it follows `poll_sec_i` one cycle later.
- R9: When the erase needs more than `LIMIT_CYC` cycles, `phase_o` becomes 4 (overtime) with `dq5_o` = 1 after `LIMIT_CYC` erase cycles. It stays there until an `other_cmd_i` pulse, which returns it to 0 with `dq5_o` = 0 and clears the selections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_cmd_i | input | 1 | One-cycle pulse: sector-erase command decoded |
| sec_idx_i | input | SEC_W | Sector addressed by the sector-erase command |
| other_cmd_i | input | 1 | One-cycle pulse: any command other than sector erase or suspend |
| susp_cmd_i | input | 1 | One-cycle pulse: erase-suspend command |
| we_fall_i | input | 1 | One-cycle pulse: falling edge of the write strobe |
| poll_sec_i | input | SEC_W | Sector of the current status poll |
| phase_o | output | 3 | 0 read, 1 window, 2 zero-fill, 3 erase, 4 overtime |
| dq7_o | output | 1 | Polling bit, low while the polled sector is busy |
| dq5_o | output | 1 | Overtime flag |
| wr_mask_o | output | NSEC | Per-sector array write enable during zero-fill and erase |

## Verification
The bench builds the block with 8 sectors, a 20-cycle window, 6 cycles of zero-fill, 10 erase cycles per sector and a 35-cycle limit. With these values the exact cycle of every phase change falls within a few dozen clocks. Three sectors (30 cycles) finish inside the limit, while four sectors (40 cycles) cross it. Both the normal completion and the overtime path are therefore reached with small batches. A window restart on its very last cycle can also be placed exactly.

// File: rtl/ebt_pkg.sv
package ebt_pkg;
  typedef enum logic [2:0] {
    PH_READ     = 3'd0,
    PH_WINDOW   = 3'd1,
    PH_ZFILL    = 3'd2,
    PH_ERASE    = 3'd3,
    PH_OVERTIME = 3'd4
  } phase_e;
endpackage

// File: rtl/ebt_window_timer.sv
module ebt_window_timer #(
  parameter int WIN_CYC = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && !restart_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i || restart_i || expire_o) cnt_q <= '0;
    else                                        cnt_q <= cnt_q + CW'(1);
  end

  // R3
  win_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && restart_i) |=> (cnt_q == '0));
endmodule

// File: rtl/ebt_sector_map.sv
module ebt_sector_map #(
  parameter int NSEC  = 16,
  parameter int SEC_W = $clog2(NSEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_i,
  input  logic [SEC_W-1:0] set_idx_i,
  input  logic             clear_i,
  output logic [NSEC-1:0]  sel_q_o,
  output logic [NSEC-1:0]  sel_d_o
);
  logic [NSEC-1:0] sel_q;

  for (genvar i = 0; i < NSEC; i++) begin : g_bit
    always_comb begin
      if (clear_i)                                   sel_d_o[i] = 1'b0;
      else if (set_i && (set_idx_i == SEC_W'(i)))    sel_d_o[i] = 1'b1;
      else                                           sel_d_o[i] = sel_q[i];
    end

    always_ff @(posedge clk) begin
      if (rst) sel_q[i] <= 1'b0;
      else     sel_q[i] <= sel_d_o[i];
    end
  end

  assign sel_q_o = sel_q;

  // R2
  set_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clear_i) |=> sel_q[$past(set_idx_i)]);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clear_i) |=> $stable(sel_q));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (sel_q == '0));
endmodule

// File: rtl/ebt_erase_seq.sv
module ebt_erase_seq
  import ebt_pkg::*;
#(
  parameter int NSEC      = 16,
  parameter int ZFILL_CYC = 1000,
  parameter int ERASE_CYC = 2000,
  parameter int LIMIT_CYC = 40000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sec_cmd_i,
  input  logic            other_cmd_i,
  input  logic            we_fall_i,
  input  logic            win_expire_i,
  input  logic [NSEC-1:0] sel_q_i,
  output phase_e          state_q_o,
  output phase_e          state_d_o,
  output logic            win_run_o,
  output logic            win_restart_o,
  output logic            map_set_o,
  output logic            map_clear_o
);
  localparam int MAX_A = (ZFILL_CYC > LIMIT_CYC) ? ZFILL_CYC : LIMIT_CYC;
  localparam int MAX_C = (MAX_A > NSEC * ERASE_CYC) ? MAX_A : NSEC * ERASE_CYC;
  localparam int CW    = $clog2(MAX_C + 2);
  localparam logic [CW-1:0] ZF_LAST = CW'(ZFILL_CYC - 1);
  localparam logic [CW-1:0] LIM_C   = CW'(LIMIT_CYC);
  localparam logic [CW-1:0] ER_C    = CW'(ERASE_CYC);

  phase_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, need_q, need_d, nsel, elapsed;

  always_comb begin
    nsel = '0;
    for (int i = 0; i < NSEC; i++) nsel = nsel + CW'(sel_q_i[i]);
  end

  assign elapsed       = cnt_q + CW'(1);
  assign win_run_o     = (state_q == PH_WINDOW);
  assign win_restart_o = sec_cmd_i || we_fall_i;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    need_d      = need_q;
    map_set_o   = 1'b0;
    map_clear_o = 1'b0;
    unique case (state_q)
      PH_READ: begin
        if (sec_cmd_i) begin
          state_d   = PH_WINDOW;
          map_set_o = 1'b1;
        end
      end
      PH_WINDOW: begin
        if (other_cmd_i) begin
          state_d     = PH_READ;
          map_clear_o = 1'b1;
        end else begin
          if (sec_cmd_i) map_set_o = 1'b1;
          if (win_expire_i) begin
            state_d = PH_ZFILL;
            cnt_d   = '0;
          end
        end
      end
      PH_ZFILL: begin
        if (cnt_q == ZF_LAST) begin
          state_d = PH_ERASE;
          cnt_d   = '0;
          need_d  = nsel * ER_C;
        end else begin
          cnt_d = elapsed;
        end
      end
      PH_ERASE: begin
        if (elapsed == need_q) begin
          state_d     = PH_READ;
          cnt_d       = '0;
          map_clear_o = 1'b1;
        end else if (elapsed == LIM_C) begin
          state_d = PH_OVERTIME;
          cnt_d   = '0;
        end else begin
          cnt_d = elapsed;
        end
      end
      PH_OVERTIME: begin
        if (other_cmd_i) begin
          state_d     = PH_READ;
          map_clear_o = 1'b1;
        end
      end
      default: state_d = PH_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_READ;
      cnt_q   <= '0;
      need_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      need_q  <= need_d;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

  // R4
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_WINDOW && other_cmd_i) |=> (state_q == PH_READ));

  // R9
  overtime_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_OVERTIME && !other_cmd_i) |=> (state_q == PH_OVERTIME));

  // R7
  zfill_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_ZFILL) |=> (state_q == PH_ZFILL || state_q == PH_ERASE));

  // R6
  erase_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PH_ERASE) |=> (state_q != PH_WINDOW && state_q != PH_ZFILL));
endmodule

// File: rtl/erase_batch_timer.sv
module erase_batch_timer
  import ebt_pkg::*;
#(
  parameter int NSEC      = 16,
  parameter int SEC_W     = $clog2(NSEC),
  parameter int WIN_CYC   = 5000,
  parameter int ZFILL_CYC = 1000,
  parameter int ERASE_CYC = 2000,
  parameter int LIMIT_CYC = 40000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sec_cmd_i,
  input  logic [SEC_W-1:0] sec_idx_i,
  input  logic             other_cmd_i,
  input  logic             susp_cmd_i,
  input  logic             we_fall_i,
  input  logic [SEC_W-1:0] poll_sec_i,
  output logic [2:0]       phase_o,
  output logic             dq7_o,
  output logic             dq5_o,
  output logic [NSEC-1:0]  wr_mask_o
);
  phase_e          state_q, state_d;
  logic            win_run, win_restart, win_expire;
  logic            map_set, map_clear;
  logic [NSEC-1:0] sel_q, sel_d;
  logic            busy_d, poll_hit_d, susp_seen;

  ebt_window_timer #(.WIN_CYC(WIN_CYC)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run_i     (win_run),
    .restart_i (win_restart),
    .expire_o  (win_expire)
  );

  ebt_sector_map #(.NSEC(NSEC), .SEC_W(SEC_W)) u_map (
    .clk       (clk),
    .rst       (rst),
    .set_i     (map_set),
    .set_idx_i (sec_idx_i),
    .clear_i   (map_clear),
    .sel_q_o   (sel_q),
    .sel_d_o   (sel_d)
  );

  ebt_erase_seq #(
    .NSEC      (NSEC),
    .ZFILL_CYC (ZFILL_CYC),
    .ERASE_CYC (ERASE_CYC),
    .LIMIT_CYC (LIMIT_CYC)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .sec_cmd_i     (sec_cmd_i),
    .other_cmd_i   (other_cmd_i),
    .we_fall_i     (we_fall_i),
    .win_expire_i  (win_expire),
    .sel_q_i       (sel_q),
    .state_q_o     (state_q),
    .state_d_o     (state_d),
    .win_run_o     (win_run),
    .win_restart_o (win_restart),
    .map_set_o     (map_set),
    .map_clear_o   (map_clear)
  );

  // suspend needs no action inside the accept window; it is only observed
  assign susp_seen  = susp_cmd_i && (state_q == PH_WINDOW);
  assign busy_d     = (state_d == PH_ZFILL) || (state_d == PH_ERASE);
  assign poll_hit_d = (state_d != PH_READ) && sel_d[poll_sec_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      dq7_o     <= 1'b1;
      dq5_o     <= 1'b0;
      wr_mask_o <= '0;
    end else begin
      dq7_o     <= !poll_hit_d;
      dq5_o     <= (state_d == PH_OVERTIME);
      wr_mask_o <= busy_d ? sel_d : '0;
    end
  end

  assign phase_o = state_q;

  // R8
  read_dq7_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o == 3'(PH_READ)) |-> dq7_o);

  // R5
  mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_o != 3'(PH_ZFILL) && phase_o != 3'(PH_ERASE)) |-> (wr_mask_o == '0));

  // R9
  dq5_phase_chk: assert property (@(posedge clk) disable iff (rst)
    dq5_o |-> (phase_o == 3'(PH_OVERTIME)));

  // R4
  susp_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (susp_seen && !other_cmd_i) |=> (phase_o != 3'(PH_READ)));
endmodule

// File: tb/test_erase_batch_timer.sv
module test_erase_batch_timer;
  localparam int NSEC = 8;
  localparam int SW   = 3;
  localparam int W    = 20;
  localparam int Z    = 6;
  localparam int E    = 10;
  localparam int L    = 35;

  typedef struct {
    int    at;
    int    ph;
    int    mask;
    int    d5;
    int    d7;
    string tag;
  } item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sec_cmd = 1'b0, other_cmd = 1'b0, susp_cmd = 1'b0, we_fall = 1'b0;
  logic [SW-1:0]   sec_idx = '0, poll_sec = '0;
  logic [2:0]      phase;
  logic            dq7, dq5;
  logic [NSEC-1:0] mask;

  int    cyc = 0;
  int    nchk = 0;
  int    nbad = 0;
  bit    ended = 1'b0;
  item_t q[$];

  erase_batch_timer #(
    .NSEC(NSEC), .SEC_W(SW), .WIN_CYC(W), .ZFILL_CYC(Z), .ERASE_CYC(E), .LIMIT_CYC(L)
  ) i_erase_batch_timer (
    .clk(clk), .rst(rst), .sec_cmd_i(sec_cmd), .sec_idx_i(sec_idx),
    .other_cmd_i(other_cmd), .susp_cmd_i(susp_cmd), .we_fall_i(we_fall),
    .poll_sec_i(poll_sec), .phase_o(phase), .dq7_o(dq7), .dq5_o(dq5), .wr_mask_o(mask)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pack(int ph, int m, int d5, int d7);
    return (ph << 16) | (m << 2) | (d5 << 1) | d7;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s cyc=%0d act=%0h exp=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic ex(int at, int ph, int m, int d5, int d7, string tag);
    item_t it;
    it.at = at; it.ph = ph; it.mask = m; it.d5 = d5; it.d7 = d7; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares each expected item in the cycle it names
  always begin : mon
    item_t it;
    int act, exp;
    @(negedge clk);
    #1;
    while (q.size() > 0 && q[0].at <= cyc) begin
      it  = q.pop_front();
      act = pack(int'(phase), int'(mask), int'(dq5), int'(dq7));
      exp = pack(it.ph, it.mask, it.d5, it.d7);
      if (it.at < cyc) chk(1'b0, {it.tag, " missed"}, it.at, cyc);
      else             chk(act == exp, it.tag, act, exp);
    end
  end

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic pulse_sec(int idx);
    sec_cmd = 1'b1; sec_idx = SW'(idx);
    @(negedge clk);
    sec_cmd = 1'b0;
  endtask

  task automatic pulse_other();
    other_cmd = 1'b1;
    @(negedge clk);
    other_cmd = 1'b0;
  endtask

  task automatic pulse_we();
    we_fall = 1'b1;
    @(negedge clk);
    we_fall = 1'b0;
  endtask

  task automatic pulse_susp();
    susp_cmd = 1'b1;
    @(negedge clk);
    susp_cmd = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog expired cyc=%0d", cyc);
    finish_run();
  end

  initial begin
    int k, k1, k2, k3, k4, kc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(phase == 3'd0 && dq7 && !dq5 && mask == '0, "R1",
        pack(int'(phase), int'(mask), int'(dq5), int'(dq7)), pack(0, 0, 0, 1));
    @(negedge clk);

    // single sector, late commands during zero-fill ignored
    poll_sec = 3'd2;
    pulse_sec(2); k = cyc;
    ex(k, 1, 0, 0, 0, "R2");
    ex(k + W - 1, 1, 0, 0, 0, "R3");
    ex(k + W, 2, 'h04, 0, 0, "R5");
    ex(k + W + Z - 1, 2, 'h04, 0, 0, "R7");
    ex(k + W + Z, 3, 'h04, 0, 0, "R5");
    ex(k + W + Z + E - 1, 3, 'h04, 0, 0, "R6");
    ex(k + W + Z + E, 0, 0, 0, 1, "R6");
    wait_cyc(k + W + 1);
    pulse_sec(7);
    pulse_other();
    wait_cyc(k + W + Z + E + 2);

    // three sectors, restarts, boundary restart, suspend ignored
    poll_sec = 3'd0;
    pulse_sec(1); k1 = cyc;
    ex(k1, 1, 0, 0, 1, "R8");
    wait_cyc(k1 + 10);
    pulse_sec(3); k2 = cyc;
    ex(k2 + W - 1, 1, 0, 0, 1, "R3");
    wait_cyc(k2 + W - 1);
    pulse_we(); k3 = cyc;
    ex(k3, 1, 0, 0, 1, "R3");
    wait_cyc(k3 + 2);
    pulse_sec(6); k4 = cyc;
    ex(k4 + W - 1, 1, 0, 0, 1, "R4");
    ex(k4 + W, 2, 'h4A, 0, 1, "R5");
    ex(k4 + W + Z, 3, 'h4A, 0, 1, "R6");
    wait_cyc(k4 + 4);
    pulse_susp();
    wait_cyc(k4 + W + Z + 5);
    poll_sec = 3'd3;
    ex(k4 + W + Z + 6, 3, 'h4A, 0, 0, "R8");
    ex(k4 + W + Z + 3 * E - 1, 3, 'h4A, 0, 0, "R6");
    ex(k4 + W + Z + 3 * E, 0, 0, 0, 1, "R6");
    wait_cyc(k4 + W + Z + 3 * E + 2);

    // abort in window
    poll_sec = 3'd4;
    @(negedge clk);
    pulse_sec(4); k = cyc;
    ex(k, 1, 0, 0, 0, "R8");
    wait_cyc(k + 4);
    pulse_other();
    ex(k + 5, 0, 0, 0, 1, "R4");
    ex(k + W + 2, 0, 0, 0, 1, "R4");
    wait_cyc(k + W + 4);

    // four sectors with a duplicate: exceeds limit
    poll_sec = 3'd2;
    pulse_sec(0); pulse_sec(1); pulse_sec(0); pulse_sec(2); pulse_sec(3);
    k = cyc;
    ex(k + W - 1, 1, 0, 0, 0, "R2");
    ex(k + W, 2, 'h0F, 0, 0, "R2");
    ex(k + W + Z + L - 1, 3, 'h0F, 0, 0, "R9");
    ex(k + W + Z + L, 4, 0, 1, 0, "R9");
    wait_cyc(k + W + Z + L + 5);
    pulse_sec(5);
    poll_sec = 3'd5;
    ex(k + W + Z + L + 8, 4, 0, 1, 1, "R7");
    ex(k + W + Z + L + 12, 4, 0, 1, 1, "R9");
    wait_cyc(k + W + Z + L + 13);
    pulse_other(); kc = cyc;
    ex(kc, 0, 0, 0, 1, "R9");
    repeat (3) @(negedge clk);
    #2;
    finish_run();
  end
endmodule